// File: doc/BRIEF.md
# Narrow Slave Bus Bridge

This block sits between a 32-bit memory-mapped master and a slave whose data path is only 8 or 16 bits wide, such as a parallel flash on a shared external bus. Each word access from the master becomes a series of narrow slave cycles at rising byte addresses. The lowest narrow beat starts at the word-aligned address. Each later beat adds the slave width in bytes.

A write visits only those narrow beats that have at least one byte lane enabled. A halfword store therefore produces exactly one write strobe on a 16-bit slave. This keeps command sequences intact, because a flash device treats every extra write strobe as a command. A read always visits every beat. The narrow read data is assembled into a 32-bit word, with the lowest address in the least significant bits. The master is held off with a wait-request until the last narrow beat has finished.

Each narrow beat has three phases: one setup cycle, a strobe phase of a programmable length, and one hold cycle. Address and write data do not change during the beat.

Top module: `narrow_bus_bridge`

## Requirements
- R1: After reset, and with no request pending, `s_cs`, `s_we`, `s_oe`, `m_rvalid` and `m_waitreq` are all low.
- R2: Beat k (k = 0 .. 32/SLV_W-1) uses slave address `(m_addr & ~3) + k*SLV_W/8`. Beats are visited in ascending order.
- R3: On a write, a beat gets chip select and a write strobe only if some bit of `m_be[k*SLV_W/8 +: SLV_W/8]` is 1. During that strobe, `s_be` carries exactly those bits and `s_wdata` carries `m_wdata[k*SLV_W +: SLV_W]`. With SLV_W=16, a write to byte address 0x04 with `m_be`=4'b0011 strobes once, at 0x04 only.
- R4: A write with `m_be`=4'b0000 raises neither `s_cs` nor `s_we`. `m_waitreq` drops one cycle after the request is first seen.
- R5: A read visits every beat, whatever `m_be` is. Bits `[k*SLV_W +: SLV_W]` of `m_rdata` hold the slave data of beat k.
- R6: `m_rvalid` is a single-cycle pulse. It is high in the cycle where a read completes with `m_waitreq` low, and it never pulses for a write.
- R7: `m_waitreq` is high from the first cycle a request is seen until the completion cycle. An access with n visited beats takes n*(WE_CYC+2)+1 cycles from its first cycle to completion.
- R8: Every visited beat has 1 cycle of `s_cs` with a stable `s_addr` before `s_we` (or the read capture), then WE_CYC strobe cycles, then 1 cycle of `s_cs` after `s_we` falls. `s_addr` and `s_wdata` stay stable throughout the beat.
- R9: `s_we` is only ever high together with `s_cs`, and never together with `s_oe`.
- R10: Bits [1:0] of `m_addr` have no effect on slave addresses or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_addr | input | ADDR_W | Master byte address |
| m_read | input | 1 | Master read request, held while waited |
| m_write | input | 1 | Master write request, held while waited |
| m_wdata | input | 32 | Master write data |
| m_be | input | 4 | Master byte enables |
| m_waitreq | output | 1 | Holds the master until the access completes |
| m_rdata | output | 32 | Assembled read word |
| m_rvalid | output | 1 | Read data valid pulse |
| s_addr | output | ADDR_W | Slave byte address of the current beat |
| s_cs | output | 1 | Slave chip select, active high |
| s_oe | output | 1 | Slave output enable (read beats) |
| s_we | output | 1 | Slave write strobe |
| s_be | output | SLV_W/8 | Slave byte lane enables |
| s_wdata | output | SLV_W | Slave write data |
| s_rdata | input | SLV_W | Slave read data |

## Verification
A corrupted pending-beat mask shows up at once at the slave pins. It appears as an extra or missing write strobe, or as a strobe at the wrong offset, within the very access in which it occurs. The beat counter and the strobe-length counter drive the completion time directly. An error in either changes the cycle on which `m_waitreq` drops, and it does so on the same transaction. A slip in the read lane index places slave data in the wrong half or quarter of `m_rdata`, which is visible at the next read completion.

// File: rtl/nb_pkg.sv
package nb_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_STROBE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_FIN    = 3'd4
    } phase_e;
endpackage

// File: rtl/nb_beat_pick.sv
// Lowest pending beat wins: beats go out in ascending address order.
module nb_beat_pick #(
    parameter int BEATS = 2,
    localparam int IW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic [BEATS-1:0] mask,
    output logic [IW-1:0]    idx,
    output logic             any
);
    always_comb begin
        idx = '0;
        any = |mask;
        for (int k = BEATS - 1; k >= 0; k--) begin
            if (mask[k]) idx = IW'(k);
        end
    end
endmodule

// File: rtl/nb_lane_mux.sv
// Selects the narrow lane of the current beat and merges read data.
module nb_lane_mux #(
    parameter int SLV_W = 16,
    parameter int IW    = 1,
    localparam int LANES = SLV_W / 8
) (
    input  logic [IW-1:0]    idx,
    input  logic [31:0]      wdata,
    input  logic [3:0]       be,
    input  logic [SLV_W-1:0] rd_in,
    input  logic [31:0]      acc_in,
    output logic [SLV_W-1:0] wlane,
    output logic [LANES-1:0] belane,
    output logic [31:0]      acc_out
);
    always_comb begin
        wlane   = wdata[int'(idx)*SLV_W +: SLV_W];
        belane  = be[int'(idx)*LANES +: LANES];
        acc_out = acc_in;
        acc_out[int'(idx)*SLV_W +: SLV_W] = rd_in;
    end
endmodule

// File: rtl/narrow_bus_bridge.sv
module narrow_bus_bridge
    import nb_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SLV_W  = 16,
    parameter int WE_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    m_addr,
    input  logic                 m_read,
    input  logic                 m_write,
    input  logic [31:0]          m_wdata,
    input  logic [3:0]           m_be,
    output logic                 m_waitreq,
    output logic [31:0]          m_rdata,
    output logic                 m_rvalid,
    output logic [ADDR_W-1:0]    s_addr,
    output logic                 s_cs,
    output logic                 s_oe,
    output logic                 s_we,
    output logic [SLV_W/8-1:0]   s_be,
    output logic [SLV_W-1:0]     s_wdata,
    input  logic [SLV_W-1:0]     s_rdata
);
    localparam int LANES = SLV_W / 8;
    localparam int BEATS = 32 / SLV_W;
    localparam int IW    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int CW    = $clog2(WE_CYC + 1);

    typedef struct packed {
        phase_e            ph;
        logic [BEATS-1:0]  pend;
        logic              wr;
        logic [ADDR_W-1:0] base;
        logic [31:0]       wdata;
        logic [3:0]        be;
        logic [31:0]       acc;
        logic [CW-1:0]     cnt;
    } st_t;

    st_t st_d, st_q;

    // Beats a write must visit: any enabled lane in that beat.
    logic [BEATS-1:0] wmask;
    for (genvar g = 0; g < BEATS; g++) begin : g_wmask
        assign wmask[g] = |m_be[g*LANES +: LANES];
    end

    logic [IW-1:0]    cur;
    logic             cur_any;
    logic [SLV_W-1:0] wlane;
    logic [LANES-1:0] belane;
    logic [31:0]      acc_nx;

    nb_beat_pick #(.BEATS(BEATS)) u_pick (
        .mask (st_q.pend),
        .idx  (cur),
        .any  (cur_any)
    );

    nb_lane_mux #(.SLV_W(SLV_W), .IW(IW)) u_lane (
        .idx     (cur),
        .wdata   (st_q.wdata),
        .be      (st_q.be),
        .rd_in   (s_rdata),
        .acc_in  (st_q.acc),
        .wlane   (wlane),
        .belane  (belane),
        .acc_out (acc_nx)
    );

    logic req;
    logic active;
    logic [BEATS-1:0] pend_clr;

    assign req    = m_read | m_write;
    assign active = (st_q.ph == PH_SETUP) || (st_q.ph == PH_STROBE) || (st_q.ph == PH_HOLD);

    always_comb begin
        pend_clr      = st_q.pend;
        pend_clr[cur] = 1'b0;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req) begin
                    st_d.wr    = m_write;
                    st_d.base  = m_addr & ~ADDR_W'(3);
                    st_d.wdata = m_wdata;
                    st_d.be    = m_be;
                    st_d.acc   = '0;
                    st_d.cnt   = '0;
                    st_d.pend  = m_write ? wmask : '1;
                    st_d.ph    = ((m_write ? wmask : '1) == '0) ? PH_FIN : PH_SETUP;
                end
            end
            PH_SETUP: begin
                st_d.ph  = PH_STROBE;
                st_d.cnt = '0;
            end
            PH_STROBE: begin
                if (st_q.cnt == CW'(WE_CYC - 1)) begin
                    st_d.ph = PH_HOLD;
                    if (!st_q.wr) st_d.acc = acc_nx;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                st_d.pend = pend_clr;
                st_d.ph   = (pend_clr == '0) ? PH_FIN : PH_SETUP;
            end
            PH_FIN:  st_d.ph = PH_IDLE;
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign s_cs      = active && cur_any;
    assign s_oe      = active && !st_q.wr;
    assign s_we      = (st_q.ph == PH_STROBE) && st_q.wr;
    assign s_addr    = st_q.base + ADDR_W'(int'(cur) * LANES);
    assign s_be      = st_q.wr ? belane : '1;
    assign s_wdata   = st_q.wr ? wlane : '0;
    assign m_waitreq = req && (st_q.ph != PH_FIN);
    assign m_rvalid  = (st_q.ph == PH_FIN) && !st_q.wr;
    assign m_rdata   = st_q.acc;

    AST_WE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        s_we |-> (s_cs && !s_oe)); // R9
    AST_NO_EMPTY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        s_we |-> (|s_be)); // R3
    AST_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_we && $past(s_we)) |-> ($stable(s_addr) && $stable(s_wdata))); // R8
    AST_SETUP_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_we) |-> ($past(s_cs) && $stable(s_addr))); // R8
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_we) |-> (s_cs && $stable(s_addr))); // R8
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid |=> !m_rvalid); // R6
    AST_RVALID_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        m_rvalid |-> !m_waitreq); // R6
endmodule

// File: tb/narrow_bus_bridge_tb.sv
`timescale 1ns/1ps
module narrow_bus_bridge_tb;
    localparam int ADDR_W = 24;
    localparam int SLV_W  = 16;
    localparam int WE_CYC = 2;
    localparam int LANES  = SLV_W / 8;
    localparam int BEATS  = 32 / SLV_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] m_addr = '0;
    logic m_read = 1'b0, m_write = 1'b0;
    logic [31:0] m_wdata = '0;
    logic [3:0] m_be = '0;
    logic m_waitreq, m_rvalid;
    logic [31:0] m_rdata;
    logic [ADDR_W-1:0] s_addr;
    logic s_cs, s_oe, s_we;
    logic [LANES-1:0] s_be;
    logic [SLV_W-1:0] s_wdata, s_rdata;

    always #10 clk = ~clk;

    narrow_bus_bridge #(.ADDR_W(ADDR_W), .SLV_W(SLV_W), .WE_CYC(WE_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_read(m_read), .m_write(m_write),
        .m_wdata(m_wdata), .m_be(m_be), .m_waitreq(m_waitreq), .m_rdata(m_rdata),
        .m_rvalid(m_rvalid), .s_addr(s_addr), .s_cs(s_cs), .s_oe(s_oe), .s_we(s_we),
        .s_be(s_be), .s_wdata(s_wdata), .s_rdata(s_rdata)
    );

    logic [7:0] mem [256];
    logic [7:0] ref_mem [256];

    always_comb begin
        for (int l = 0; l < LANES; l++) s_rdata[l*8 +: 8] = mem[8'(s_addr[7:0] + 8'(l))];
    end

    int tests = 0, fails = 0;
    int strobes = 0, cs_cycles = 0, setup_err = 0, pulse_err = 0, hold_err = 0, r9_err = 0, plen = 0;
    logic [ADDR_W-1:0] first_addr, addr_prev;
    logic we_prev = 1'b0, cs_prev = 1'b0;
    bit done = 0;

    // Slave model and pin monitor
    always @(posedge clk) begin
        if (rst_n) begin
            if (s_cs) cs_cycles++;
            if (s_we) begin
                if (!we_prev) begin
                    if (strobes == 0) first_addr = s_addr;
                    strobes++;
                    if (!(cs_prev && addr_prev == s_addr)) setup_err++;
                    plen = 0;
                end
                plen++;
                for (int l = 0; l < LANES; l++)
                    if (s_be[l]) mem[8'(s_addr[7:0] + 8'(l))] = s_wdata[l*8 +: 8];
                if (!s_cs || s_oe) r9_err++;
            end else if (we_prev) begin
                if (plen != WE_CYC) pulse_err++;
                if (!s_cs) hold_err++;
            end
        end
        we_prev = s_we; cs_prev = s_cs; addr_prev = s_addr;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int beats_needed(input logic [3:0] be, input bit wr);
        int n = 0;
        if (!wr) return BEATS;
        for (int k = 0; k < BEATS; k++) if (|be[k*LANES +: LANES]) n++;
        return n;
    endfunction

    function automatic logic [31:0] ref_word(input logic [7:0] a);
        logic [31:0] w;
        for (int b = 0; b < 4; b++) w[b*8 +: 8] = ref_mem[8'(a + 8'(b))];
        return w;
    endfunction

    task automatic clear_mon();
        strobes = 0; cs_cycles = 0; setup_err = 0; pulse_err = 0; hold_err = 0; r9_err = 0;
    endtask

    task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, input logic [3:0] be,
                          output int cyc, output logic [31:0] rd, output bit rv);
        @(negedge clk);
        clear_mon();
        m_addr = a; m_wdata = d; m_be = be; m_write = wr; m_read = !wr;
        #1;
        check(m_waitreq == 1'b1, "R7", "waitreq in first cycle", m_waitreq, 1);
        cyc = 0;
        rv = 0; rd = '0;
        while (cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (!m_waitreq) break;
        end
        rv = m_rvalid; rd = m_rdata;
        m_write = 0; m_read = 0;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be);
        int cyc; logic [31:0] rd; bit rv; int n; logic [7:0] base;
        n = beats_needed(be, 1);
        base = a[7:0] & 8'hFC;
        access(1, a, d, be, cyc, rd, rv);
        for (int b = 0; b < 4; b++) if (be[b]) ref_mem[8'(base + 8'(b))] = d[b*8 +: 8];
        check(cyc == n*(WE_CYC+2)+1, (n == 0) ? "R4" : "R7", "completion cycles", cyc, n*(WE_CYC+2)+1);
        check(strobes == n, "R3", "strobe count", strobes, n);
        if (n == 0) check(cs_cycles == 0, "R4", "chip select cycles", cs_cycles, 0);
        check(rv == 1'b0, "R6", "rvalid on write", rv, 0);
        check(setup_err == 0 && pulse_err == 0 && hold_err == 0, "R8", "beat timing errors",
              setup_err + pulse_err + hold_err, 0);
        check(r9_err == 0, "R9", "strobe without cs or with oe", r9_err, 0);
        begin
            int bad = 0;
            for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
            check(bad == 0, "R3", "slave memory mismatches", bad, 0);
        end
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [3:0] be);
        int cyc; logic [31:0] rd; bit rv; logic [31:0] exp;
        exp = ref_word(a[7:0] & 8'hFC);
        access(0, a, 32'h0, be, cyc, rd, rv);
        check(rd == exp, "R5", "read word", rd, exp);
        check(rv == 1'b1, "R6", "rvalid at completion", rv, 1);
        check(cyc == BEATS*(WE_CYC+2)+1, "R7", "read cycles", cyc, BEATS*(WE_CYC+2)+1);
        check(cs_cycles == BEATS*(WE_CYC+2), "R5", "read cs cycles", cs_cycles, BEATS*(WE_CYC+2));
        @(negedge clk);
        check(m_rvalid == 1'b0, "R6", "rvalid single pulse", m_rvalid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'($urandom);
            ref_mem[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        check({s_cs, s_we, s_oe, m_rvalid, m_waitreq} == 5'b0, "R1", "outputs in reset",
              {s_cs, s_we, s_oe, m_rvalid, m_waitreq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({s_cs, s_we, s_oe, m_rvalid, m_waitreq} == 5'b0, "R1", "outputs idle after reset",
              {s_cs, s_we, s_oe, m_rvalid, m_waitreq}, 0);

        // R3: halfword at 0x04, low lanes: exactly one strobe at 0x04
        do_write(24'h000004, 32'hBEEF_1234, 4'b0011);
        check(first_addr == 24'h000004, "R3", "single strobe address", first_addr, 24'h4);
        // R2: upper halfword lands at +2
        do_write(24'h000004, 32'hCAFE_5678, 4'b1100);
        check(first_addr == 24'h000006, "R2", "upper beat address", first_addr, 24'h6);
        // R2: straddling lanes give two ascending beats, first at base
        do_write(24'h000010, 32'h1122_3344, 4'b0110);
        check(first_addr == 24'h000010, "R2", "first beat address", first_addr, 24'h10);
        // R4: nothing enabled
        do_write(24'h000020, 32'hFFFF_FFFF, 4'b0000);
        // R10: low address bits ignored
        do_write(24'h000033, 32'hA5A5_5A5A, 4'b1111);
        check(first_addr == 24'h000030, "R10", "low bits dropped", first_addr, 24'h30);
        do_read(24'h000032, 4'b0001);  // R5 R10: reads ignore be and low bits
        do_read(24'h000004, 4'b1111);

        for (int t = 0; t < 300; t++) begin
            logic [ADDR_W-1:0] a;
            a = {8'($urandom), 8'($urandom), 8'($urandom)};
            if ($urandom % 3 == 0) do_read(a, 4'($urandom));
            else do_write(a, $urandom, 4'($urandom));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule